// File: doc/BRIEF.md
# HMAC Final-Block Padder

This block closes out the message feed for the second stage of an HMAC-SHA-256 computation. A key block has already gone through the hash engine, so the block builds the SHA-256 padding and the length field for a message that follows that key block. Any full 64-byte message blocks that come before the tail are handed through unchanged. A start strobe then carries the total message byte count. The block collects the leftover bytes one at a time, 0 to 63 of them, and then presents one or two 512-bit blocks. Each block is tagged either as a normal continuation block or as the padded final block.

The output side uses a valid/ready handshake. The hash engine takes each block and uses the final tag to decide when the digest is complete. After the final-tagged block is accepted, a one-cycle done pulse marks the end of the message.

The control is a five-state machine:
- `ST_IDLE` waits. It moves to `ST_PASS` when a full block is offered and to `ST_FILL` on start.
- `ST_PASS` presents a passed-through block and returns to `ST_IDLE` when that block is accepted.
- `ST_FILL` collects tail bytes and moves to `ST_TAIL` once the last expected byte is stored.
- `ST_TAIL` presents the tail block. On acceptance it returns to `ST_IDLE` if the length field fitted, and otherwise moves to `ST_EXTRA`.
- `ST_EXTRA` presents the length-only block and returns to `ST_IDLE` on acceptance.

Top module: `hmac_tail_padder`

## Requirements
- R1: After reset, `out_valid`, `done` and `tail_ready` are low and `in_blk_ready` is high.
- R2: A full block accepted on `in_blk_*` while idle appears unchanged on `out_block` with `out_final` low.
- R3: In the tail block, byte lane k (lane 0 in bits [511:504], lane k in bits [511-8k -: 8]) holds the k-th tail byte for k below the tail count. The lane equal to the tail count holds 0x80, and every later lane that is not part of the length field holds 0x00.
- R4: The final block carries the 64-bit value (total message bytes × 8 + 512) in lanes 56..63, most significant byte in lane 56.
- R5: When the tail count is 55 or less, exactly one block follows the start, and it is tagged final.
- R6: When the tail count is 56 or more, the tail block is tagged normal and has zeros after the 0x80 up to lane 63. It is followed by a final-tagged block that is all zero except the length field.
- R7: When the tail count is zero (empty message or a multiple of 64 bytes), a single final block follows, with 0x80 in lane 0, zeros, and the length field.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_block` and `out_final` hold their values.
- R9: `done` is high for exactly one cycle, namely the cycle after a final-tagged block is accepted, and at no other time.
- R10: `tail_ready` is high only while bytes are being collected and fewer than the tail count have been taken. It is never high together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_blk_valid | input | 1 | A full 64-byte message block is offered |
| in_blk_data | input | 512 | Full message block, byte 0 in bits [511:504] |
| in_blk_ready | output | 1 | Full block accepted this cycle when valid is also high |
| start | input | 1 | Begins the tail; sampled only while idle |
| msg_len | input | LEN_W | Total message byte count, valid with `start`; its low 6 bits give the tail count |
| tail_valid | input | 1 | A tail byte is offered |
| tail_byte | input | 8 | Tail byte, in message order |
| tail_ready | output | 1 | Tail byte accepted when valid is also high |
| out_valid | output | 1 | Output block is present |
| out_ready | input | 1 | Consumer takes the output block |
| out_block | output | 512 | Output block, byte 0 in bits [511:504] |
| out_final | output | 1 | 1 = padded final block, 0 = normal continuation block |
| done | output | 1 | One-cycle pulse after the final block is accepted |

## Verification
The hardest case to reach from the ports is the two-block ending. It needs a tail of 56 to 63 bytes, and the consumer must stall in `ST_TAIL`, so that the stored bytes have to stay steady while the length-only block waits behind them. The bench drives directed tails of 55, 56 and 63 bytes and draws further tail counts at random. It also holds `out_ready` low on random cycles, which covers stalls in every output state, including back-to-back stalls across the move from `ST_TAIL` to `ST_EXTRA`.

// File: rtl/hmac_pad_pkg.sv
package hmac_pad_pkg;

    parameter int BLK_BYTES = 64;
    parameter int LEN_BYTES = 8;

    localparam int BLK_W    = 8 * BLK_BYTES;
    localparam int LEN_W64  = 8 * LEN_BYTES;
    localparam int IDX_W    = $clog2(BLK_BYTES);
    localparam int LEN_LANE = BLK_BYTES - LEN_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_FILL,
        ST_TAIL,
        ST_EXTRA
    } pad_state_e;

endpackage

// File: rtl/hp_block_store.sv
module hp_block_store
    import hmac_pad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_all,
    input  logic [BLK_W-1:0] load_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    output logic [BLK_W-1:0] data_o
);

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q <= 8'h00;
            end else if (load_all) begin
                lane_q <= load_data[8*(BLK_BYTES-1-i) +: 8];
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                lane_q <= wr_byte;
            end
        end
        assign data_o[8*(BLK_BYTES-1-i) +: 8] = lane_q;
    end

endmodule

// File: rtl/hp_len_calc.sv
module hp_len_calc
    import hmac_pad_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0]   msg_len,
    output logic [LEN_W64-1:0] bit_len
);

    localparam int KEY_BITS = BLK_W;

    logic [LEN_W64-1:0] len_ext;

    assign len_ext = LEN_W64'(msg_len);
    assign bit_len = (len_ext << 3) + LEN_W64'(KEY_BITS);

endmodule

// File: rtl/hp_block_image.sv
module hp_block_image
    import hmac_pad_pkg::*;
(
    input  logic [BLK_W-1:0]   data_i,
    input  logic [IDX_W-1:0]   tail_i,
    input  logic [LEN_W64-1:0] bit_len_i,
    input  logic               extra_i,
    output logic               fits_o,
    output logic [BLK_W-1:0]   image_o
);

    assign fits_o = (int'(tail_i) < LEN_LANE);

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
        logic [7:0] lane_v;
        if (i >= LEN_LANE) begin : g_len_lane
            always_comb begin
                lane_v = 8'h00;
                if (extra_i) begin
                    lane_v = bit_len_i[8*(BLK_BYTES-1-i) +: 8];
                end else if (i < int'(tail_i)) begin
                    lane_v = data_i[8*(BLK_BYTES-1-i) +: 8];
                end else if (i == int'(tail_i)) begin
                    lane_v = 8'h80;
                end else if (fits_o) begin
                    lane_v = bit_len_i[8*(BLK_BYTES-1-i) +: 8];
                end
            end
        end else begin : g_data_lane
            always_comb begin
                lane_v = 8'h00;
                if (!extra_i) begin
                    if (i < int'(tail_i)) begin
                        lane_v = data_i[8*(BLK_BYTES-1-i) +: 8];
                    end else if (i == int'(tail_i)) begin
                        lane_v = 8'h80;
                    end
                end
            end
        end
        assign image_o[8*(BLK_BYTES-1-i) +: 8] = lane_v;
    end

endmodule

// File: rtl/hmac_tail_padder.sv
module hmac_tail_padder
    import hmac_pad_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_blk_valid,
    input  logic [BLK_W-1:0] in_blk_data,
    output logic             in_blk_ready,
    input  logic             start,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             tail_valid,
    input  logic [7:0]       tail_byte,
    output logic             tail_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_block,
    output logic             out_final,
    output logic             done
);

    pad_state_e state_q, state_d;

    logic [LEN_W-1:0]   len_q;
    logic [IDX_W-1:0]   idx_q;
    logic               done_q;
    logic [IDX_W-1:0]   tail_cnt;
    logic [BLK_W-1:0]   store_q;
    logic [BLK_W-1:0]   image;
    logic [LEN_W64-1:0] bit_len;
    logic               fits;
    logic               start_acc;
    logic               pass_acc;
    logic               byte_acc;
    logic               fill_full;
    logic               out_acc;

    assign tail_cnt  = len_q[IDX_W-1:0];
    assign fill_full = (idx_q == tail_cnt);
    assign start_acc = (state_q == ST_IDLE) && start;
    assign pass_acc  = in_blk_valid && in_blk_ready;
    assign byte_acc  = tail_valid && tail_ready;
    assign out_acc   = out_valid && out_ready;

    hp_block_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_acc),
        .load_all (pass_acc),
        .load_data(in_blk_data),
        .wr_en    (byte_acc),
        .wr_idx   (idx_q),
        .wr_byte  (tail_byte),
        .data_o   (store_q)
    );

    hp_len_calc #(.LEN_W(LEN_W)) u_len (
        .msg_len(len_q),
        .bit_len(bit_len)
    );

    hp_block_image u_image (
        .data_i   (store_q),
        .tail_i   (tail_cnt),
        .bit_len_i(bit_len),
        .extra_i  (state_q == ST_EXTRA),
        .fits_o   (fits),
        .image_o  (image)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FILL;
                end else if (in_blk_valid) begin
                    state_d = ST_PASS;
                end
            end
            ST_PASS: begin
                if (out_ready) state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (fill_full) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (out_ready) state_d = fits ? ST_IDLE : ST_EXTRA;
            end
            ST_EXTRA: begin
                if (out_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_blk_ready = 1'b0;
        tail_ready   = 1'b0;
        out_valid    = 1'b0;
        out_final    = 1'b0;
        out_block    = image;
        unique case (state_q)
            ST_IDLE: begin
                in_blk_ready = !start;
            end
            ST_PASS: begin
                out_valid = 1'b1;
                out_block = store_q;
            end
            ST_FILL: begin
                tail_ready = !fill_full;
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_final = fits;
            end
            ST_EXTRA: begin
                out_valid = 1'b1;
                out_final = 1'b1;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= out_acc && out_final;
            if (start_acc) begin
                len_q <= msg_len;
                idx_q <= '0;
            end else if (byte_acc) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/hmac_tail_padder_chk.sv
module hmac_tail_padder_chk
    import hmac_pad_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_blk_ready,
    input logic             tail_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_block,
    input logic             out_final,
    input logic             done
);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final)));

    p_done_after_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_final) |=> done);

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && out_final));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_tail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_ready |-> !out_valid);

    p_pass_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_blk_ready |-> (!out_valid && !tail_ready));

endmodule

bind hmac_tail_padder hmac_tail_padder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_blk_ready(in_blk_ready),
    .tail_ready  (tail_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_block   (out_block),
    .out_final   (out_final),
    .done        (done)
);

// File: tb/hmac_tail_padder_tb_top.sv
module hmac_tail_padder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_blk_valid;
    logic [511:0]     in_blk_data;
    logic             in_blk_ready;
    logic             start;
    logic [LEN_W-1:0] msg_len;
    logic             tail_valid;
    logic [7:0]       tail_byte;
    logic             tail_ready;
    logic             out_valid;
    logic             out_ready;
    logic [511:0]     out_block;
    logic             out_final;
    logic             done;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] tb_tail [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    hmac_tail_padder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_blk_valid(in_blk_valid), .in_blk_data(in_blk_data), .in_blk_ready(in_blk_ready),
        .start(start), .msg_len(msg_len),
        .tail_valid(tail_valid), .tail_byte(tail_byte), .tail_ready(tail_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
        .out_final(out_final), .done(done)
    );

    function automatic logic [511:0] ref_block(int tail, int total, bit second);
        logic [63:0]  bl;
        logic [511:0] r;
        logic [7:0]   v;
        bl = 64'(total) * 64'd8 + 64'd512;
        r  = '0;
        for (int b = 0; b < 64; b++) begin
            v = 8'h00;
            if (second) begin
                if (b >= 56) v = bl[8*(63-b) +: 8];
            end else if (b < tail) begin
                v = tb_tail[b];
            end else if (b == tail) begin
                v = 8'h80;
            end else if (tail <= 55 && b >= 56) begin
                v = bl[8*(63-b) +: 8];
            end
            r[511-8*b -: 8] = v;
        end
        return r;
    endfunction

    task automatic chk_blk(string req, logic [511:0] act, logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s block actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic get_block(output logic [511:0] blk, output logic fin);
        bit got = 0;
        bit held = 0;
        logic [511:0] hb = '0;
        logic hf = 1'b0;
        bit r;
        while (!got) begin
            if (out_valid) begin
                chk_bit("R10 tail_ready with out_valid", tail_ready, 1'b0);
                if (held) begin
                    chk_blk("R8 held block", out_block, hb);
                    chk_bit("R8 held tag", out_final, hf);
                end
                r = ($urandom % 3) != 0;
                out_ready = r;
                if (r) begin
                    blk = out_block;
                    fin = out_final;
                    got = 1;
                end else begin
                    held = 1;
                    hb = out_block;
                    hf = out_final;
                end
            end else begin
                if (held) chk_bit("R8 valid dropped", out_valid, 1'b1);
                held = 0;
                out_ready = 1'b0;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic send_pass(logic [511:0] blk);
        in_blk_valid = 1'b1;
        in_blk_data  = blk;
        while (!in_blk_ready) @(negedge clk);
        @(negedge clk);
        in_blk_valid = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        if ($urandom % 4 == 0) @(negedge clk);
        tail_valid = 1'b1;
        tail_byte  = b;
        while (!tail_ready) @(negedge clk);
        @(negedge clk);
        tail_valid = 1'b0;
    endtask

    task automatic run_msg(int nfull, int tail);
        int total;
        logic [511:0] blk, got_b;
        logic fin;
        total = nfull * 64 + tail;
        for (int k = 0; k < nfull; k++) begin
            for (int w = 0; w < 16; w++) blk[32*w +: 32] = $urandom;
            send_pass(blk);
            get_block(got_b, fin);
            chk_blk("R2 passthrough", got_b, blk);
            chk_bit("R2 passthrough tag", fin, 1'b0);
        end
        for (int j = 0; j < 64; j++) tb_tail[j] = 8'($urandom);
        start   = 1'b1;
        msg_len = LEN_W'(total);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < tail; j++) send_byte(tb_tail[j]);
        get_block(got_b, fin);
        if (tail == 0) begin
            chk_blk("R7 zero-tail block", got_b, ref_block(tail, total, 0));
        end else begin
            chk_blk("R3 tail block", got_b, ref_block(tail, total, 0));
        end
        if (tail <= 55) begin
            chk_bit("R5 single block final", fin, 1'b1);
            chk_blk("R4 length field", {448'd0, got_b[63:0]},
                    {448'd0, 64'(total) * 64'd8 + 64'd512});
        end else begin
            chk_bit("R6 overflow block normal", fin, 1'b0);
            chk_bit("R9 no done after normal", done, 1'b0);
            get_block(got_b, fin);
            chk_blk("R6 length-only block", got_b, ref_block(tail, total, 1));
            chk_bit("R6 second block final", fin, 1'b1);
        end
        chk_bit("R9 done pulse", done, 1'b1);
        @(negedge clk);
        chk_bit("R9 done one cycle", done, 1'b0);
        chk_bit("R5 no extra block", out_valid, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        in_blk_valid = 1'b0;
        in_blk_data  = '0;
        start = 1'b0;
        msg_len = '0;
        tail_valid = 1'b0;
        tail_byte = '0;
        out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 out_valid", out_valid, 1'b0);
        chk_bit("R1 done", done, 1'b0);
        chk_bit("R1 tail_ready", tail_ready, 1'b0);
        chk_bit("R1 in_blk_ready", in_blk_ready, 1'b1);

        run_msg(0, 0);
        run_msg(2, 0);
        run_msg(0, 1);
        run_msg(0, 55);
        run_msg(0, 56);
        run_msg(1, 57);
        run_msg(0, 63);
        run_msg(2, 63);
        for (int t = 0; t < 40; t++) begin
            run_msg(int'($urandom % 3), int'($urandom % 64));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule